// File: doc/BRIEF.md
# Bit-Maskable GPIO Bank Register Block

This block holds the software-visible state of one 32-pin general-purpose I/O bank behind a plain memory-mapped 32-bit bus with byte address, write strobe, write data and read data. It keeps an output data value, a direction value and an output-enable value for every pin. It also brings the pad inputs through a two-flop synchronizer so that software can read them.

Output data is written through two half-word masked-write registers, one for pins 0 to 15 and one for pins 16 to 31. Each write carries a 16-bit mask in its upper half and 16 data bits in its lower half, so software can change any subset of pins with a single store and no read-modify-write. A pin is driven only when both its direction bit and its output-enable bit are 1.

A parameter selects which bank slot the block answers to, and all register offsets follow from it. A second parameter can mark two pin positions as output-only. Once their direction bits are set to 1, software cannot clear them. Read data is combinational from the address. The chip's reset logic releases the active-low reset synchronously to the clock.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset the output data, direction and output-enable state are all 0. Both pad outputs are 0, and reads of the direction and output-enable registers return 0.
- R2: A write to the low masked register at byte offset 0x000+8*BANK carries its mask in bits 31:16 and its data in bits 15:0. Each output pin n in 0..15 whose mask bit 16+n is 0 takes data bit n.
- R3: A write to the high masked register at 0x004+8*BANK uses the same layout and sends data bit n to output pin n+16. It leaves pins 0..15 unchanged.
- R4: Where a mask bit is 1, the matching stored output bit keeps its value.
- R5: Reads of the masked registers and of any unmapped offset return 0. Writes to unmapped offsets change no state.
- R6: The input register at 0x060+4*BANK returns the pad inputs as they were two clock edges earlier, through two synchronizing flops.
- R7: The direction register at 0x204+0x40*BANK reads back as written, where 1 means output. A pin's pad enable is 1 only when its direction bit and output-enable bit are both 1.
- R8: The output-enable register at 0x208+0x40*BANK reads back as written.
- R9: With LOCK_EN=1, direction bits 7 and 8 stay at 1 once they are 1, whatever is written to them later. All other direction bits follow the written value.
- R10: The block decodes only the offsets of its own BANK slot. A write to the same register in another bank's slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pad_in | input | DATA_W | Raw pad inputs |
| pad_out | output | DATA_W | Output data value per pin |
| pad_oe | output | DATA_W | Per-pin driver enable |

## Verification
The bench builds the block with BANK=1 and LOCK_EN=1. With these values the bank-1 offsets are in use while the bank-0 offsets at 0x000 and 0x208 are foreign slots, so writes there can be shown to be ignored. The output-only pins 7 and 8 can be tried by clearing the whole direction register. Masks that split bytes across both halves show that the kept bits and the written bits meet correctly. A pad change is read after one edge and again after two, which brackets the synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned LO_BASE   = 'h000;
  localparam int unsigned LO_STRIDE = 8;
  localparam int unsigned HI_BASE   = 'h004;
  localparam int unsigned IN_BASE   = 'h060;
  localparam int unsigned IN_STRIDE = 4;
  localparam int unsigned DIR_BASE  = 'h204;
  localparam int unsigned OEN_BASE  = 'h208;
  localparam int unsigned CTL_STRIDE = 'h40;

  typedef struct packed {
    logic lo;
    logic hi;
    logic dir;
    logic oen;
  } wr_sel_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned NSTAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [NSTAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTAGE; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < NSTAGE; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign dout = stg_q[NSTAGE-1];

  generate
    if (NSTAGE == 2) begin : g_chk
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           warm_q <= '0;
        else if (warm_q != 2) warm_q <= warm_q + 2'd1;
      end
      // R6
      sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_mask_out.sv
module gpio_mask_out #(
  parameter int unsigned HALF = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [2*HALF-1:0] wdata,
  output logic [2*HALF-1:0] out_q
);
  localparam int unsigned W = 2 * HALF;

  logic [HALF-1:0] msk, dat;
  logic [W-1:0]    out_nxt;
  logic            out_en;

  assign msk    = wdata[W-1:HALF];
  assign dat    = wdata[HALF-1:0];
  assign out_en = wr_lo | wr_hi;

  always_comb begin
    out_nxt = out_q;
    if (wr_lo) out_nxt[HALF-1:0] = (out_q[HALF-1:0] & msk) | (dat & ~msk);
    if (wr_hi) out_nxt[W-1:HALF] = (out_q[W-1:HALF] & msk) | (dat & ~msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_nxt;
  end

  // R4
  lo_mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> ((out_q[HALF-1:0] & $past(msk)) == ($past(out_q[HALF-1:0]) & $past(msk))));
  // R3
  hi_spares_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (out_q[HALF-1:0] == $past(out_q[HALF-1:0])));
endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl #(
  parameter int unsigned W       = 32,
  parameter bit          LOCK_EN = 1'b1,
  parameter int unsigned LOCK_A  = 7,
  parameter int unsigned LOCK_B  = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_oen,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oen_q
);
  localparam logic [W-1:0] LK = LOCK_EN ?
    ((W'(1) << LOCK_A) | (W'(1) << LOCK_B)) : '0;

  logic [W-1:0] dir_nxt, oen_nxt;

  always_comb begin
    dir_nxt = wdata | (dir_q & LK);
    oen_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= dir_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oen_q <= '0;
    else if (wr_oen) oen_q <= oen_nxt;
  end

  // R9
  dir_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & LK) != '0) |=> ((dir_q & $past(dir_q) & LK) == ($past(dir_q) & LK)));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned BANK    = 0,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NSYNC   = 2,
  parameter bit          LOCK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe
);
  localparam int unsigned HALF   = DATA_W / 2;
  localparam int unsigned WA     = ADDR_W - 2;
  localparam logic [WA-1:0] A_LO  = WA'((LO_BASE  + LO_STRIDE  * BANK) >> 2);
  localparam logic [WA-1:0] A_HI  = WA'((HI_BASE  + LO_STRIDE  * BANK) >> 2);
  localparam logic [WA-1:0] A_IN  = WA'((IN_BASE  + IN_STRIDE  * BANK) >> 2);
  localparam logic [WA-1:0] A_DIR = WA'((DIR_BASE + CTL_STRIDE * BANK) >> 2);
  localparam logic [WA-1:0] A_OEN = WA'((OEN_BASE + CTL_STRIDE * BANK) >> 2);

  logic [WA-1:0]     waddr;
  wr_sel_t           sel;
  logic [DATA_W-1:0] dir_q, oen_q, in_s;

  assign waddr = bus_addr[ADDR_W-1:2];

  always_comb begin
    sel.lo  = bus_wr && (waddr == A_LO);
    sel.hi  = bus_wr && (waddr == A_HI);
    sel.dir = bus_wr && (waddr == A_DIR);
    sel.oen = bus_wr && (waddr == A_OEN);
  end

  gpio_mask_out #(.HALF(HALF)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_lo(sel.lo), .wr_hi(sel.hi),
    .wdata(bus_wdata), .out_q(pad_out));

  gpio_dir_ctrl #(.W(DATA_W), .LOCK_EN(LOCK_EN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_dir(sel.dir), .wr_oen(sel.oen),
    .wdata(bus_wdata), .dir_q(dir_q), .oen_q(oen_q));

  gpio_in_sync #(.W(DATA_W), .NSTAGE(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_s));

  assign pad_oe = dir_q & oen_q;

  always_comb begin
    bus_rdata = '0;
    if      (waddr == A_IN)  bus_rdata = in_s;
    else if (waddr == A_DIR) bus_rdata = dir_q;
    else if (waddr == A_OEN) bus_rdata = oen_q;
  end

  // R7
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.dir && bus_wdata == '0 && !LOCK_EN) |=> (pad_oe == '0));
endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int total = 0, bad = 0;
  logic [31:0] q_exp [$];
  string       q_tag [$];
  event        mon_ev;

  always #4 clk = ~clk;

  gpio_bank_regs #(.BANK(1), .LOCK_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    -> mon_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(mon_ev);
      while (q_exp.size() > 0) chk(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
    end
  end

  task automatic pads(input logic [31:0] eo, input logic [31:0] ee, input string tag);
    @(negedge clk);
    chk({tag, " pad_out"}, pad_out, eo);
    chk({tag, " pad_oe"}, pad_oe, ee);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    pads(32'h0, 32'h0, "R1");
    rd(12'h244, 32'h0, "R1 dir");
    rd(12'h248, 32'h0, "R1 oen");
    // R2 low half masked write
    wr(12'h008, 32'h0000_A5A5);
    pads(32'h0000_A5A5, 32'h0, "R2");
    // R3 high half
    wr(12'h00C, 32'h0000_1234);
    pads(32'h1234_A5A5, 32'h0, "R3");
    // R4 partial masks
    wr(12'h008, 32'hFF00_005A);
    pads(32'h1234_A55A, 32'h0, "R4 lo");
    wr(12'h00C, 32'h0F0F_FFFF);
    pads(32'hF2F4_A55A, 32'h0, "R4 hi");
    wr(12'h00C, 32'hFFFF_0000);
    pads(32'hF2F4_A55A, 32'h0, "R4 full mask");
    // R5 write-only and unmapped
    rd(12'h008, 32'h0, "R5 lo read");
    rd(12'h00C, 32'h0, "R5 hi read");
    rd(12'h100, 32'h0, "R5 unmapped read");
    wr(12'h100, 32'hFFFF_FFFF);
    pads(32'hF2F4_A55A, 32'h0, "R5 unmapped write");
    // R10 other bank's slots
    wr(12'h000, 32'h0000_0000);
    pads(32'hF2F4_A55A, 32'h0, "R10 bank0 lo");
    wr(12'h208, 32'hFFFF_FFFF);
    rd(12'h248, 32'h0, "R10 bank0 oen");
    // R7 direction, R8 output enable
    wr(12'h244, 32'h0000_FFFF);
    rd(12'h244, 32'h0000_FFFF, "R7 dir");
    pads(32'hF2F4_A55A, 32'h0, "R7 no oen");
    wr(12'h248, 32'h00FF_00FF);
    rd(12'h248, 32'h00FF_00FF, "R8 oen");
    pads(32'hF2F4_A55A, 32'h0000_00FF, "R7 and");
    // R9 locked pins
    wr(12'h244, 32'h0000_0000);
    rd(12'h244, 32'h0000_0180, "R9 lock");
    pads(32'hF2F4_A55A, 32'h0000_0080, "R9 oe");
    wr(12'h244, 32'h8000_0001);
    rd(12'h244, 32'h8000_0181, "R9 others follow");
    // R6 synchronizer latency
    @(negedge clk); pad_in = 32'hDEAD_BEEF; bus_addr = 12'h064;
    @(negedge clk); #1;
    chk("R6 one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R6 two edges", bus_rdata, 32'hDEAD_BEEF);
    @(negedge clk); pad_in = 32'h0F0F_0F0F;
    @(negedge clk);
    @(negedge clk);
    rd(12'h064, 32'h0F0F_0F0F, "R6 second value");
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule